// File: doc/BRIEF.md
# Masked Sample Frame Packer

This block turns one sample interval from a multi-group electrode front end into a byte stream for a radio transceiver. The sample interval arrives as one wide word, one 16-bit sample per channel. A channel-enable mask picks which channels go out. A resolution code sets how many leading bits of each kept sample are sent. The kept samples are then packed end to end into bytes. Every frame starts with a short header that repeats the configuration in force for that frame, so the receiver can unpack the payload without keeping any state of its own.

Before a frame can use a mask, the mask is turned into a list of active channel numbers. A scanner builds this list, visiting one channel per cycle. Writing a new mask cancels any frame that is in progress and restarts the scan. Packing resumes once the new list is complete. Sample intervals are taken in only while a measurement is switched on, the transceiver reports ready, no list rebuild is running, and the previous frame has left the output register.

The default build has 8 groups of 16 channels. Both counts are parameters.

Top module: `chan_frame_packer`

## Requirements
- R1: After reset, `out_valid` and `smp_ready` are low, and the mask, filter, rate and resolution registers read zero.
- R2: Each frame opens with 2 + N/8 header bytes, where N is the channel count. Byte 0 is {resolution[3:0], filter[3:0]}. Byte 1 is the rate. Byte 2+k is mask bits [8k+7:8k].
- R3: After the header, only channels whose mask bit is 1 are sent, in ascending channel order. Mask bit i enables channel i.
- R4: A resolution code c from 8 to 15 sends the c most significant bits of each sample. Any code from 0 to 7 sends all 16 bits.
- R5: Kept samples are concatenated MSB first with no gap between them. Only the last payload byte of a frame is padded, with zeros in its low bits.
- R6: An all-zero mask gives a frame made only of the header.
- R7: `smp_ready` is high only if `meas_on` has been pulsed, no `meas_off` pulse has come since, `xcvr_ready` is high, no list rebuild is pending, and `out_valid` is low. If `meas_on` and `meas_off` pulse in the same cycle, `meas_off` wins.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R9: A `mask_wr` pulse cancels the current frame. `out_valid` is low in the following cycle, and no byte of the cancelled frame appears afterwards. The next frame uses the new mask.
- R10: Filter, rate and resolution are captured when a sample interval is accepted. A `param_wr` during a frame leaves that frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mask_wr | input | 1 | Write strobe for the channel mask |
| mask_in | input | N | New channel mask |
| param_wr | input | 1 | Write strobe for filter, rate and resolution |
| filt_in | input | 4 | Filter setting, carried in the header |
| rate_in | input | 8 | Rate setting, carried in the header |
| res_in | input | 4 | Resolution code |
| meas_on | input | 1 | Pulse that starts the measurement |
| meas_off | input | 1 | Pulse that stops the measurement |
| xcvr_ready | input | 1 | Transceiver is ready |
| smp_valid | input | 1 | A sample interval is offered |
| smp_ready | output | 1 | The offered interval is accepted |
| smp_data | input | 16N | Samples; channel i occupies bits [16i+15:16i] |
| out_valid | output | 1 | An output byte is valid |
| out_ready | input | 1 | The sink takes the byte |
| out_data | output | 8 | Output byte |

## Verification
The assertions assume that `out_ready` is the only thing that can stall a presented byte, and that `mask_wr` is the only thing allowed to withdraw one. The bench keeps to this: it raises `mask_wr` on purpose in a single test and checks the withdrawal there. Stimulus changes on the falling clock edge. `smp_valid` stays high until a handshake happens and then drops. `meas_on` and `meas_off` are never pulsed in the same cycle. The bench builds each expected frame bit by bit from the mask, the resolution and the samples. It sweeps all sixteen resolution codes across several masks while `out_ready` follows a pseudo-random stall pattern.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    localparam int SAMPLE_W = 16;
    localparam int ACC_W    = 24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA
    } pk_state_e;

    // Number of leading sample bits kept for a resolution code.
    // Codes below 8 fall back to the full sample width.
    function automatic logic [4:0] res_width(input logic [3:0] code);
        return (code >= 4'd8) ? {1'b0, code} : 5'(SAMPLE_W);
    endfunction

endpackage

// File: rtl/cfp_cfg_regs.sv
module cfp_cfg_regs #(
    parameter int NUM_CH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic [NUM_CH-1:0] mask_in,
    input  logic              param_wr,
    input  logic [3:0]        filt_in,
    input  logic [7:0]        rate_in,
    input  logic [3:0]        res_in,
    output logic [NUM_CH-1:0] mask_q,
    output logic [3:0]        filt_q,
    output logic [7:0]        rate_q,
    output logic [3:0]        res_q,
    output logic              mask_new
);

    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic [3:0]        filt;
        logic [7:0]        rate;
        logic [3:0]        res;
        logic              fresh;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d       = cfg_q;
        cfg_d.fresh = 1'b0;
        if (mask_wr) begin
            cfg_d.mask  = mask_in;
            cfg_d.fresh = 1'b1;
        end
        if (param_wr) begin
            cfg_d.filt = filt_in;
            cfg_d.rate = rate_in;
            cfg_d.res  = res_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mask_q   = cfg_q.mask;
    assign filt_q   = cfg_q.filt;
    assign rate_q   = cfg_q.rate;
    assign res_q    = cfg_q.res;
    assign mask_new = cfg_q.fresh;

endmodule

// File: rtl/cfp_chan_list.sv
module cfp_chan_list #(
    parameter int NUM_CH = 128,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int CNT_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_CH-1:0] mask,
    output logic              busy,
    output logic [CNT_W-1:0]  count,
    input  logic [CH_W-1:0]   rd_idx,
    output logic [CH_W-1:0]   rd_ch
);

    typedef struct packed {
        logic                          busy;
        logic [CH_W-1:0]               scan;
        logic [CNT_W-1:0]              cnt;
        logic [NUM_CH-1:0][CH_W-1:0]   list;
    } lst_t;

    lst_t lst_d, lst_q;

    // One channel is visited per cycle, so a rebuild takes NUM_CH cycles.
    always_comb begin
        lst_d = lst_q;
        if (start) begin
            lst_d.busy = 1'b1;
            lst_d.scan = '0;
            lst_d.cnt  = '0;
        end else if (lst_q.busy) begin
            if (mask[lst_q.scan]) begin
                lst_d.list[lst_q.cnt[CH_W-1:0]] = lst_q.scan;
                lst_d.cnt = lst_q.cnt + CNT_W'(1);
            end
            if (lst_q.scan == CH_W'(NUM_CH - 1)) lst_d.busy = 1'b0;
            else                                 lst_d.scan = lst_q.scan + CH_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lst_q <= '0;
        else        lst_q <= lst_d;
    end

    assign busy  = lst_q.busy;
    assign count = lst_q.cnt;
    assign rd_ch = lst_q.list[rd_idx];

endmodule

// File: rtl/cfp_sample_pick.sv
module cfp_sample_pick #(
    parameter int NUM_CH   = 128,
    parameter int SAMPLE_W = 16,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic [NUM_CH*SAMPLE_W-1:0] samples,
    input  logic [CH_W-1:0]            ch,
    input  logic [4:0]                 width,
    output logic [SAMPLE_W-1:0]        value
);

    logic [SAMPLE_W-1:0] raw;
    logic [4:0]          drop;

    // Keep the top 'width' bits, right-aligned.
    always_comb begin
        raw   = samples[ch*SAMPLE_W +: SAMPLE_W];
        drop  = 5'(SAMPLE_W) - width;
        value = raw >> drop;
    end

endmodule

// File: rtl/chan_frame_packer.sv
module chan_frame_packer
    import cfp_pkg::*;
#(
    parameter int NUM_GROUPS   = 8,
    parameter int CH_PER_GROUP = 16,
    localparam int NUM_CH      = NUM_GROUPS * CH_PER_GROUP,
    localparam int CH_W        = $clog2(NUM_CH),
    localparam int CNT_W       = $clog2(NUM_CH + 1),
    localparam int HDR_BYTES   = 2 + NUM_CH / 8,
    localparam int HB_W        = $clog2(HDR_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mask_wr,
    input  logic [NUM_CH-1:0]          mask_in,
    input  logic                       param_wr,
    input  logic [3:0]                 filt_in,
    input  logic [7:0]                 rate_in,
    input  logic [3:0]                 res_in,
    input  logic                       meas_on,
    input  logic                       meas_off,
    input  logic                       xcvr_ready,
    input  logic                       smp_valid,
    output logic                       smp_ready,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [7:0]                 out_data
);

    logic [NUM_CH-1:0]   mask_q;
    logic [3:0]          filt_q;
    logic [7:0]          rate_q;
    logic [3:0]          res_q;
    logic                mask_new;
    logic                list_busy;
    logic [CNT_W-1:0]    list_cnt;
    logic [CH_W-1:0]     cur_ch;
    logic [SAMPLE_W-1:0] cur_val;

    typedef struct packed {
        pk_state_e                   state;
        logic                        running;
        logic [NUM_CH*SAMPLE_W-1:0]  samples;
        logic [4:0]                  width;
        logic [3:0]                  filt;
        logic [7:0]                  rate;
        logic [3:0]                  res;
        logic [HB_W-1:0]             hidx;
        logic [CNT_W-1:0]            ptr;
        logic [ACC_W-1:0]            acc;
        logic [4:0]                  acc_n;
        logic                        ov;
        logic [7:0]                  ob;
    } pk_t;

    pk_t pk_d, pk_q;

    cfp_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_wr  (mask_wr),
        .mask_in  (mask_in),
        .param_wr (param_wr),
        .filt_in  (filt_in),
        .rate_in  (rate_in),
        .res_in   (res_in),
        .mask_q   (mask_q),
        .filt_q   (filt_q),
        .rate_q   (rate_q),
        .res_q    (res_q),
        .mask_new (mask_new)
    );

    cfp_chan_list #(.NUM_CH(NUM_CH)) u_list (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (mask_new),
        .mask   (mask_q),
        .busy   (list_busy),
        .count  (list_cnt),
        .rd_idx (pk_q.ptr[CH_W-1:0]),
        .rd_ch  (cur_ch)
    );

    cfp_sample_pick #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_pick (
        .samples (pk_q.samples),
        .ch      (cur_ch),
        .width   (pk_q.width),
        .value   (cur_val)
    );

    logic            rebuild;
    logic            slot_free;
    logic [HB_W-1:0] mask_byte;

    always_comb begin
        pk_d      = pk_q;
        rebuild   = mask_wr | mask_new | list_busy;
        slot_free = !pk_q.ov || out_ready;
        mask_byte = pk_q.hidx - HB_W'(2);

        if (meas_on)  pk_d.running = 1'b1;
        if (meas_off) pk_d.running = 1'b0;

        if (pk_q.ov && out_ready) pk_d.ov = 1'b0;

        smp_ready = pk_q.running && xcvr_ready && !rebuild &&
                    (pk_q.state == ST_IDLE) && !pk_q.ov;

        unique case (pk_q.state)
            ST_IDLE: begin
                if (smp_valid && smp_ready) begin
                    pk_d.samples = smp_data;
                    pk_d.width   = res_width(res_q);
                    pk_d.filt    = filt_q;
                    pk_d.rate    = rate_q;
                    pk_d.res     = res_q;
                    pk_d.hidx    = '0;
                    pk_d.ptr     = '0;
                    pk_d.acc_n   = '0;
                    pk_d.state   = ST_HDR;
                end
            end
            ST_HDR: begin
                if (slot_free) begin
                    pk_d.ov = 1'b1;
                    if (pk_q.hidx == HB_W'(0))      pk_d.ob = {pk_q.res, pk_q.filt};
                    else if (pk_q.hidx == HB_W'(1)) pk_d.ob = pk_q.rate;
                    else                            pk_d.ob = mask_q[mask_byte*8 +: 8];
                    if (pk_q.hidx == HB_W'(HDR_BYTES - 1)) pk_d.state = ST_DATA;
                    else                                   pk_d.hidx  = pk_q.hidx + HB_W'(1);
                end
            end
            ST_DATA: begin
                if (pk_q.acc_n >= 5'd8) begin
                    if (slot_free) begin
                        pk_d.ov    = 1'b1;
                        pk_d.ob    = 8'(pk_q.acc >> (pk_q.acc_n - 5'd8));
                        pk_d.acc_n = pk_q.acc_n - 5'd8;
                    end
                end else if (pk_q.ptr < list_cnt) begin
                    pk_d.acc   = (pk_q.acc << pk_q.width) | ACC_W'(cur_val);
                    pk_d.acc_n = pk_q.acc_n + pk_q.width;
                    pk_d.ptr   = pk_q.ptr + CNT_W'(1);
                end else if (pk_q.acc_n != 5'd0) begin
                    if (slot_free) begin
                        pk_d.ov    = 1'b1;
                        pk_d.ob    = 8'(pk_q.acc << (5'd8 - pk_q.acc_n));
                        pk_d.acc_n = 5'd0;
                    end
                end else begin
                    pk_d.state = ST_IDLE;
                end
            end
            default: pk_d.state = ST_IDLE;
        endcase

        if (mask_wr) begin
            pk_d.state = ST_IDLE;
            pk_d.ov    = 1'b0;
            pk_d.acc_n = 5'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign out_valid = pk_q.ov;
    assign out_data  = pk_q.ob;

endmodule

// File: rtl/cfp_checker.sv
module cfp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mask_wr,
    input logic       meas_off,
    input logic       xcvr_ready,
    input logic       smp_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data
);

    assert_accept_needs_xcvr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> xcvr_ready);

    assert_accept_after_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> !out_valid);

    assert_stop_blocks_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        meas_off |=> !smp_ready);

    assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !mask_wr) |=> (out_valid && $stable(out_data)));

    assert_mask_cancels_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (!out_valid && !smp_ready));

endmodule

bind chan_frame_packer cfp_checker u_chk (.*);

// File: tb/sim_chan_frame_packer.sv
module sim_chan_frame_packer;

    localparam int CLK_PERIOD = 10;
    localparam int NG  = 2;
    localparam int CPG = 8;
    localparam int NCH = NG * CPG;
    localparam int SW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mask_wr = 1'b0;
    logic [NCH-1:0]    mask_in = '0;
    logic              param_wr = 1'b0;
    logic [3:0]        filt_in = '0;
    logic [7:0]        rate_in = '0;
    logic [3:0]        res_in = '0;
    logic              meas_on = 1'b0;
    logic              meas_off = 1'b0;
    logic              xcvr_ready = 1'b0;
    logic              smp_valid = 1'b0;
    logic              smp_ready;
    logic [NCH*SW-1:0] smp_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [7:0]        out_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;
    logic [15:0] stall = 16'hACE1;
    logic [NCH-1:0] cur_mask = '0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_frame_packer #(.NUM_GROUPS(NG), .CH_PER_GROUP(CPG)) u0 (
        .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_in(mask_in),
        .param_wr(param_wr), .filt_in(filt_in), .rate_in(rate_in), .res_in(res_in),
        .meas_on(meas_on), .meas_off(meas_off), .xcvr_ready(xcvr_ready),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic bit next_ready();
        stall = {stall[14:0], stall[15] ^ stall[13] ^ stall[12] ^ stall[10]};
        return stall[0] | stall[3];
    endfunction

    // Expected frame, built bit by bit from the requirement text.
    function automatic void build_expected(input logic [NCH-1:0] m, input logic [3:0] r,
                                           input logic [7:0] rt, input logic [3:0] f,
                                           input logic [NCH*SW-1:0] s);
        bit bq[$];
        int w;
        logic [SW-1:0] v;
        logic [7:0] b;
        exp_q.delete();
        exp_q.push_back({r, f});
        exp_q.push_back(rt);
        for (int k = 0; k < NCH / 8; k++) exp_q.push_back(m[8*k +: 8]);
        w = (r >= 4'd8) ? int'(r) : 16;
        for (int ch = 0; ch < NCH; ch++) begin
            if (m[ch]) begin
                v = s[ch*SW +: SW];
                for (int i = 0; i < w; i++) bq.push_back(v[SW-1-i]);
            end
        end
        while (bq.size() > 0) begin
            b = '0;
            for (int k = 0; k < 8; k++) b = {b[6:0], (bq.size() > 0) ? bq.pop_front() : 1'b0};
            exp_q.push_back(b);
        end
    endfunction

    task automatic offer_interval(input logic [NCH*SW-1:0] s);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = s;
        while (!smp_ready) @(negedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic run_frame(input logic [NCH-1:0] m, input logic [3:0] r,
                             input logic [7:0] rt, input logic [3:0] f,
                             input int poke_at, input string tag);
        logic [NCH*SW-1:0] s;
        int got = 0;
        int bad = 0;
        int extra = 0;
        int guard = 0;
        bit poked = 0;
        logic [7:0] bad_act = '0;
        logic [7:0] bad_exp = '0;
        @(negedge clk);
        param_wr = 1'b1; res_in = r; rate_in = rt; filt_in = f;
        @(negedge clk);
        param_wr = 1'b0;
        if (m != cur_mask) begin
            mask_wr = 1'b1; mask_in = m;
            @(negedge clk);
            mask_wr = 1'b0;
            cur_mask = m;
        end
        for (int ch = 0; ch < NCH; ch++) s[ch*SW +: SW] = next_rand()[15:0];
        build_expected(m, r, rt, f, s);
        offer_interval(s);
        while (got < exp_q.size() && guard < 2000) begin
            out_ready = next_ready();
            if (got == poke_at && !poked) begin
                param_wr = 1'b1; res_in = ~r; rate_in = ~rt; filt_in = ~f;
                poked = 1;
            end else begin
                param_wr = 1'b0;
            end
            if (out_valid && out_ready) begin
                if (out_data !== exp_q[got] && bad == 0) begin
                    bad_act = out_data;
                    bad_exp = exp_q[got];
                end
                if (out_data !== exp_q[got]) bad++;
                got++;
            end
            guard++;
            @(negedge clk);
        end
        param_wr = 1'b0;
        out_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (out_valid) extra++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(bad == 0, tag, "frame byte", 64'(bad_act), 64'(bad_exp));
        chk(got == exp_q.size() && extra == 0, tag, "frame length",
            64'(got + extra), 64'(exp_q.size()));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NCH-1:0] masks [5];
        logic [NCH*SW-1:0] s;
        int seen;
        string tag;
        masks[0] = 16'hFFFF; masks[1] = 16'h0000; masks[2] = 16'hC003;
        masks[3] = 16'h8001; masks[4] = 16'h5A3C;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 0);
        chk(smp_ready == 1'b0, "R1", "smp_ready after reset", 64'(smp_ready), 0);

        // R7: measurement on but transceiver not ready
        meas_on = 1'b1; @(negedge clk); meas_on = 1'b0;
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            if (smp_ready) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R7", "accept without transceiver", 64'(seen), 0);
        xcvr_ready = 1'b1;
        @(negedge clk);
        chk(smp_ready == 1'b1, "R7", "accept when enabled", 64'(smp_ready), 1);
        meas_off = 1'b1; @(negedge clk); meas_off = 1'b0;
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            if (smp_ready) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R7", "accept after stop", 64'(seen), 0);
        meas_on = 1'b1; @(negedge clk); meas_on = 1'b0;

        // R1: a header-only frame taken right after reset shows zero mask registers
        build_expected('0, 4'd0, 8'd0, 4'd0, '0);
        offer_interval('0);
        seen = 0;
        out_ready = 1'b1;
        for (int i = 0; i < 12; i++) begin
            if (out_valid && out_data != 8'h00) seen++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(seen == 0, "R1", "reset register bytes", 64'(seen), 0);

        // R2 R3 R4 R5 R6 R8: all resolution codes against several masks
        foreach (masks[mi]) begin
            for (int r = 0; r < 16; r++) begin
                tag = (masks[mi] == '0) ? "R6 R2 R8" : ((r < 8) ? "R4 R3 R5 R2 R8" : "R3 R5 R4 R2 R8");
                run_frame(masks[mi], 4'(r), 8'(next_rand()), 4'(next_rand()), -1, tag);
            end
        end

        // R10: parameter write while a frame is draining
        run_frame(16'hFFFF, 4'd12, 8'h3C, 4'h5, 3, "R10");
        run_frame(16'h0F0F, 4'd9,  8'hA1, 4'h2, 10, "R10");

        // R9: cancel a frame part way through
        run_frame(16'hFFFF, 4'd0, 8'h11, 4'h1, -1, "R9");
        for (int ch = 0; ch < NCH; ch++) s[ch*SW +: SW] = next_rand()[15:0];
        offer_interval(s);
        out_ready = 1'b1;
        seen = 0;
        while (seen < 5) begin
            if (out_valid) seen++;
            @(negedge clk);
        end
        mask_wr = 1'b1; mask_in = 16'h00F0; out_ready = 1'b0;
        @(negedge clk);
        mask_wr = 1'b0;
        cur_mask = 16'h00F0;
        chk(out_valid == 1'b0, "R9", "out_valid after cancel", 64'(out_valid), 0);
        out_ready = 1'b1;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (out_valid) seen++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(seen == 0, "R9", "bytes after cancel", 64'(seen), 0);
        run_frame(16'h00F0, 4'd10, 8'h77, 4'h9, -1, "R9");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule